// File: doc/BRIEF.md
# NAND Flash Section-Mapped Access Controller

This block turns simple single-byte host accesses into NAND flash bus cycles. The host sees an 18-bit byte window split into three 64 KB sections. Data lives at offset 0x00000, commands at 0x10000 and addresses at 0x20000. The section an access falls in sets the command-latch and address-latch lines for that cycle. Writing one byte into the command section therefore issues a command cycle. Software sends a full flash address as four or five back-to-back writes into the address section. A read or write in the data section moves one byte over the 8-bit flash bus.

Every bus cycle is built from three phases: setup, strobe and hold. Each phase has its own programmable length. A fourth count sets how long the data bus stays released at the start of a write. The timing and section fields are captured when a request is accepted, so they cannot change in the middle of a cycle.

The flash ready/busy line passes through a two-flop synchronizer. When waiting is enabled and the synchronized line is low, chip enable stays low and no new request is taken. The same synchronized line feeds three sticky interrupt sources: rising edge, high level and falling edge.

The cycle state machine has five states:
- `ST_IDLE`: bus released, requests accepted.
- `ST_SETUP`: chip enable and latch lines asserted, strobe not yet active.
- `ST_STROBE`: read or write enable low.
- `ST_HOLD`: strobe released, address and latch lines kept stable.
- `ST_BUSY`: chip enable held low while the flash reports busy.

Its transitions are:
- `ST_IDLE`→`ST_SETUP` when a request is accepted.
- `ST_IDLE`→`ST_BUSY` when waiting is enabled and ready/busy is low.
- `ST_SETUP`→`ST_STROBE` after SET+1 clocks.
- `ST_STROBE`→`ST_HOLD` after WAIT+1 clocks.
- `ST_HOLD`→`ST_IDLE` after HOLD+1 clocks, or `ST_HOLD`→`ST_BUSY` if the wait condition holds at that point.
- `ST_BUSY`→`ST_IDLE` once ready/busy is high or waiting is disabled.

Top module: `nand_sect_ctrl`

## Requirements
- R1: During a cycle, `nf_cle` equals bit 16 and `nf_ale` equals bit 17 of the accepted offset, so data section (0x00000) gives both low, command section (0x10000) gives `nf_cle` high, and address section (0x20000) gives `nf_ale` high; both are low outside a cycle.
- R2: Each access holds `nf_ce_n` low for exactly (SET+1)+(WAIT+1)+(HOLD+1) clocks when no busy wait follows.
- R3: After SET+1 setup clocks with `nf_ce_n` low, the strobe goes low for exactly WAIT+1 clocks. The strobe is `nf_we_n` for writes and `nf_re_n` for reads; the other strobe stays high.
- R4: Within a cycle, `nf_cle` and `nf_ale` stay stable through the hold phase up to the clock `nf_ce_n` rises.
- R5: On a write, `nf_dq_oe` stays low for the first HIZ+1 clocks of the cycle, then is high with `nf_dq_o` equal to the write byte for the rest of the cycle. On a read it stays low.
- R6: A read captures `nf_dq_i` on the last strobe clock. `rsp_valid` is high for one clock with that byte on `rsp_rdata`. Writes never raise `rsp_valid`.
- R7: With `cfg_wait_en` high and the synchronized `nf_rb` low, `nf_ce_n` stays low and `req_ready` stays low. `nf_ce_n` rises within a few clocks after `nf_rb` returns high.
- R8: With `cfg_wait_en` low, a low `nf_rb` has no effect on `nf_ce_n` or `req_ready` once a cycle ends.
- R9: `irq_status` bit 0 latches a rising edge, bit 1 latches the high level, and bit 2 latches a falling edge of synchronized `nf_rb`. Each bit is gated by its own enable, and `irq` is the OR of the bits.
- R10: A set status bit stays set until a one-clock pulse on the matching `irq_clr` bit. If the set condition is present in that clock, setting wins over clearing.
- R11: After reset `nf_ce_n`, `nf_re_n` and `nf_we_n` are high, `nf_cle`, `nf_ale`, `nf_dq_oe` and `irq` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte offset in the window (selects the section) |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted this clock when high with `req_valid` |
| rsp_valid | output | 1 | One-clock read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| cfg_setup | input | 4 | Setup phase count SET |
| cfg_wait | input | 4 | Strobe phase count WAIT |
| cfg_hold | input | 4 | Hold phase count HOLD |
| cfg_hiz | input | 4 | Write bus release count HIZ |
| cfg_wait_en | input | 1 | Stall on ready/busy low |
| cfg_irq_rise_en | input | 1 | Enable rising-edge interrupt |
| cfg_irq_level_en | input | 1 | Enable high-level interrupt |
| cfg_irq_fall_en | input | 1 | Enable falling-edge interrupt |
| irq_clr | input | 3 | Per-bit status clear pulse |
| irq_status | output | 3 | Sticky status {fall, level, rise} |
| irq | output | 1 | Interrupt request |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_re_n | output | 1 | Flash read enable, active low |
| nf_we_n | output | 1 | Flash write enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_dq_o | output | 8 | Data bus output value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_i | input | 8 | Data bus input value |
| nf_rb | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench measures every access clock by clock and checks seven things. An off-by-one phase counter would show up as chip enable or strobe lengths one clock off, and zero counts are included to expose it. The latch lines must not drop early in the hold phase, and the largest offset of each section must not spill into a neighbour. On writes it checks that the bus turnaround is neither too short nor skipped. On reads it checks that the byte is taken on the last strobe clock and not one clock early. With waiting enabled, a controller that released chip enable during busy, or accepted a new request, would be caught. With waiting disabled, it would be caught if it still stalled. Each interrupt source is also checked for a bit that fails to stay set or that a clear cannot overcome.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_BUSY
    } cyc_state_t;

    localparam int unsigned IRQ_RISE  = 0;
    localparam int unsigned IRQ_LEVEL = 1;
    localparam int unsigned IRQ_FALL  = 2;
    localparam int unsigned IRQ_NUM   = 3;
endpackage

// File: rtl/nsc_sect_decode.sv
module nsc_sect_decode #(
    parameter int unsigned AW      = 18,
    parameter int unsigned CMD_BIT = 16,
    parameter int unsigned ADR_BIT = 17
) (
    input  logic [AW-1:0] addr,
    output logic          cle,
    output logic          ale
);
    // R1: section bits drive the latch lines directly
    assign cle = addr[CMD_BIT];
    assign ale = addr[ADR_BIT];

    logic unused_offset_bits;
    assign unused_offset_bits = ^addr;
endmodule

// File: rtl/nsc_rb_sync.sv
module nsc_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_s,
    output logic rb_rise,
    output logic rb_fall
);
    logic meta_q, sync_q, prev_q;

    // reset to "ready" so no spurious edge appears after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rb_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rb_s    = sync_q;
    assign rb_rise = sync_q & ~prev_q;
    assign rb_fall = ~sync_q & prev_q;
endmodule

// File: rtl/nsc_irq_gen.sv
module nsc_irq_gen
    import nsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rb_s,
    input  logic               rb_rise,
    input  logic               rb_fall,
    input  logic               en_rise,
    input  logic               en_level,
    input  logic               en_fall,
    input  logic [IRQ_NUM-1:0] clr,
    output logic [IRQ_NUM-1:0] status,
    output logic               irq
);
    logic [IRQ_NUM-1:0] evt, en;

    always_comb begin
        evt            = '0;
        en             = '0;
        evt[IRQ_RISE]  = rb_rise;
        evt[IRQ_LEVEL] = rb_s;
        evt[IRQ_FALL]  = rb_fall;
        en[IRQ_RISE]   = en_rise;
        en[IRQ_LEVEL]  = en_level;
        en[IRQ_FALL]   = en_fall;
    end

    for (genvar i = 0; i < IRQ_NUM; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (evt[i] && en[i])
                status[i] <= 1'b1;      // set wins over clear
            else if (clr[i])
                status[i] <= 1'b0;
        end

        AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr[i]) |=> status[i]); // R10
    end

    assign irq = |status;
endmodule

// File: rtl/nsc_cycle_fsm.sv
module nsc_cycle_fsm
    import nsc_pkg::*;
#(
    parameter int unsigned CW = 4,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_cle,
    input  logic          req_ale,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_hiz,
    input  logic          wait_en,
    input  logic          rb_s,
    input  logic [DW-1:0] dq_i,
    output logic          ce_n,
    output logic          re_n,
    output logic          we_n,
    output logic          cle,
    output logic          ale,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          in_cycle
);
    localparam int unsigned EW = CW + 2;
    localparam logic [EW-1:0] ELAP_MAX = '1;

    cyc_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [EW-1:0] elap;
    logic [CW-1:0] set_q, wait_q, hold_q, hiz_q;
    logic          wr_q, cle_q, ale_q;
    logic [DW-1:0] data_q;
    logic          busy_stall, accept, last_strobe;

    assign busy_stall  = wait_en & ~rb_s;
    assign accept      = (state == ST_IDLE) && !busy_stall && req_valid;
    assign last_strobe = (state == ST_STROBE) && (cnt == wait_q);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (busy_stall)     nxt = ST_BUSY;
                else if (req_valid) nxt = ST_SETUP;
            end
            ST_SETUP:  if (cnt == set_q)  nxt = ST_STROBE;
            ST_STROBE: if (cnt == wait_q) nxt = ST_HOLD;
            ST_HOLD: begin
                if (cnt == hold_q) nxt = busy_stall ? ST_BUSY : ST_IDLE;
            end
            ST_BUSY:   if (!busy_stall)   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            elap  <= '0;
        end else begin
            state <= nxt;
            if (nxt != state || nxt == ST_IDLE || nxt == ST_BUSY)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
            if (accept)
                elap <= '0;
            else if (elap != ELAP_MAX)
                elap <= elap + 1'b1;
        end
    end

    // access capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            cle_q  <= 1'b0;
            ale_q  <= 1'b0;
            data_q <= '0;
            set_q  <= '0;
            wait_q <= '0;
            hold_q <= '0;
            hiz_q  <= '0;
        end else if (accept) begin
            wr_q   <= req_write;
            cle_q  <= req_cle;
            ale_q  <= req_ale;
            data_q <= req_wdata;
            set_q  <= cfg_setup;
            wait_q <= cfg_wait;
            hold_q <= cfg_hold;
            hiz_q  <= cfg_hiz;
        end
    end

    // read capture on the last strobe clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= last_strobe && !wr_q;
            if (last_strobe && !wr_q)
                rsp_rdata <= dq_i;
        end
    end

    // outputs from the state register
    always_comb begin
        in_cycle  = 1'b0;
        ce_n      = 1'b1;
        re_n      = 1'b1;
        we_n      = 1'b1;
        cle       = 1'b0;
        ale       = 1'b0;
        dq_oe     = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = !busy_stall;
            ST_SETUP, ST_STROBE, ST_HOLD: begin
                in_cycle = 1'b1;
                ce_n     = 1'b0;
                cle      = cle_q;
                ale      = ale_q;
                dq_oe    = wr_q && (elap > EW'(hiz_q));
                if (state == ST_STROBE) begin
                    we_n = !wr_q;
                    re_n = wr_q;
                end
            end
            ST_BUSY:  ce_n = 1'b0;
            default:  ;
        endcase
    end

    assign dq_o = data_q;

    AST_STROBE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt != wait_q) |=> (state == ST_STROBE)); // R3

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(!ce_n)); // R3

    AST_BUSY_KEEPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && wait_en && !rb_s) |=> (!ce_n && !req_ready)); // R7

    AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6

    AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && re_n)); // R5
endmodule

// File: rtl/nand_sect_ctrl.sv
module nand_sect_ctrl
    import nsc_pkg::*;
#(
    parameter int unsigned AW = 18,
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_wait,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_hiz,
    input  logic          cfg_wait_en,
    input  logic          cfg_irq_rise_en,
    input  logic          cfg_irq_level_en,
    input  logic          cfg_irq_fall_en,
    input  logic [2:0]    irq_clr,
    output logic [2:0]    irq_status,
    output logic          irq,
    output logic          nf_ce_n,
    output logic          nf_re_n,
    output logic          nf_we_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic [DW-1:0] nf_dq_o,
    output logic          nf_dq_oe,
    input  logic [DW-1:0] nf_dq_i,
    input  logic          nf_rb
);
    logic dec_cle, dec_ale;
    logic rb_s, rb_rise, rb_fall;
    logic in_cycle;

    nsc_sect_decode #(.AW(AW), .CMD_BIT(16), .ADR_BIT(17)) u_dec (
        .addr (req_addr),
        .cle  (dec_cle),
        .ale  (dec_ale)
    );

    nsc_rb_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nf_rb),
        .rb_s     (rb_s),
        .rb_rise  (rb_rise),
        .rb_fall  (rb_fall)
    );

    nsc_cycle_fsm #(.CW(CW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cle   (dec_cle),
        .req_ale   (dec_ale),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .cfg_setup (cfg_setup),
        .cfg_wait  (cfg_wait),
        .cfg_hold  (cfg_hold),
        .cfg_hiz   (cfg_hiz),
        .wait_en   (cfg_wait_en),
        .rb_s      (rb_s),
        .dq_i      (nf_dq_i),
        .ce_n      (nf_ce_n),
        .re_n      (nf_re_n),
        .we_n      (nf_we_n),
        .cle       (nf_cle),
        .ale       (nf_ale),
        .dq_o      (nf_dq_o),
        .dq_oe     (nf_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .in_cycle  (in_cycle)
    );

    nsc_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_s     (rb_s),
        .rb_rise  (rb_rise),
        .rb_fall  (rb_fall),
        .en_rise  (cfg_irq_rise_en),
        .en_level (cfg_irq_level_en),
        .en_fall  (cfg_irq_fall_en),
        .clr      (irq_clr),
        .status   (irq_status),
        .irq      (irq)
    );

    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R3

    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cycle && $past(in_cycle)) |-> ($stable(nf_cle) && $stable(nf_ale))); // R4

    AST_LATCH_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        nf_ce_n |-> (!nf_cle && !nf_ale)); // R1

    AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status != 3'b000) |-> irq); // R9
endmodule

// File: tb/nand_sect_ctrl_test.sv
`timescale 1ns/1ps
module nand_sect_ctrl_test;
    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [7:0]  data;
        logic [3:0]  s;
        logic [3:0]  w;
        logic [3:0]  h;
        logic [3:0]  z;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 18'h10000, 8'h70, 4'd0,  4'd0,  4'd0,  4'd0},
        '{1'b1, 18'h20000, 8'h12, 4'd1,  4'd2,  4'd1,  4'd1},
        '{1'b1, 18'h20004, 8'h34, 4'd2,  4'd1,  4'd0,  4'd3},
        '{1'b1, 18'h00010, 8'hA5, 4'd0,  4'd3,  4'd2,  4'd0},
        '{1'b0, 18'h00000, 8'hC3, 4'd1,  4'd1,  4'd1,  4'd0},
        '{1'b0, 18'h0FFFF, 8'h5C, 4'd3,  4'd0,  4'd2,  4'd0},
        '{1'b1, 18'h1FFFF, 8'hFF, 4'd15, 4'd15, 4'd15, 4'd15},
        '{1'b0, 18'h2ABCD, 8'h3C, 4'd0,  4'd4,  4'd0,  4'd0}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [7:0] req_wdata = '0, nf_dq_i = '0;
    logic [3:0] cfg_setup = '0, cfg_wait = '0, cfg_hold = '0, cfg_hiz = '0;
    logic cfg_wait_en = 0, cfg_irq_rise_en = 0, cfg_irq_level_en = 0, cfg_irq_fall_en = 0;
    logic [2:0] irq_clr = '0;
    logic nf_rb = 1;
    logic req_ready, rsp_valid, irq, nf_ce_n, nf_re_n, nf_we_n, nf_cle, nf_ale, nf_dq_oe;
    logic [7:0] rsp_rdata, nf_dq_o;
    logic [2:0] irq_status;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nand_sect_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_setup(cfg_setup),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz),
        .cfg_wait_en(cfg_wait_en), .cfg_irq_rise_en(cfg_irq_rise_en),
        .cfg_irq_level_en(cfg_irq_level_en), .cfg_irq_fall_en(cfg_irq_fall_en),
        .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq),
        .nf_ce_n(nf_ce_n), .nf_re_n(nf_re_n), .nf_we_n(nf_we_n),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
        .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // issue one access and measure the whole cycle
    task automatic run_access(input vec_t v, output int ce_cnt, output int setup_cnt,
                              output int strobe_cnt, output int wrong_strobe,
                              output int latch_err, output int hz_cnt,
                              output int data_err, output int rsp_ok, output int rsp_seen);
        bit seen_strobe = 0;
        ce_cnt = 0; setup_cnt = 0; strobe_cnt = 0; wrong_strobe = 0;
        latch_err = 0; hz_cnt = 0; data_err = 0; rsp_ok = 0; rsp_seen = 0;
        cfg_setup = v.s; cfg_wait = v.w; cfg_hold = v.h; cfg_hiz = v.z;
        nf_dq_i = v.data;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
        @(negedge clk);
        req_valid = 0;
        req_addr = 18'h3FFFF;
        while (!nf_ce_n) begin
            ce_cnt++;
            if (nf_cle !== v.addr[16] || nf_ale !== v.addr[17]) latch_err++;
            if (v.wr) begin
                if (!nf_we_n) begin strobe_cnt++; seen_strobe = 1; end
                if (!nf_re_n) wrong_strobe++;
                if (!nf_dq_oe) hz_cnt++;
                else if (nf_dq_o !== v.data) data_err++;
            end else begin
                if (!nf_re_n) begin strobe_cnt++; seen_strobe = 1; end
                if (!nf_we_n) wrong_strobe++;
                if (nf_dq_oe) hz_cnt++;
            end
            if (!seen_strobe) setup_cnt++;
            if (rsp_valid) begin
                rsp_seen++;
                if (rsp_rdata === v.data) rsp_ok = 1;
            end
            @(negedge clk);
            if (ce_cnt > 200) break;
        end
        if (rsp_valid) rsp_seen++;
    endtask

    initial begin
        int ce_cnt, setup_cnt, strobe_cnt, wrong_strobe, latch_err, hz_cnt, data_err, rsp_ok, rsp_seen;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 ce_n", nf_ce_n, 1);
        chk("R11 re_n/we_n", {nf_re_n, nf_we_n}, 3);
        chk("R11 cle/ale/oe", {nf_cle, nf_ale, nf_dq_oe}, 0);
        chk("R11 irq", irq, 0);
        chk("R11 req_ready", req_ready, 1);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int tot = v.s + v.w + v.h + 3;
            int hz_exp = v.wr ? (((v.z + 1) < tot) ? (v.z + 1) : tot) : 0;
            run_access(v, ce_cnt, setup_cnt, strobe_cnt, wrong_strobe, latch_err,
                       hz_cnt, data_err, rsp_ok, rsp_seen);
            chk($sformatf("R2 ce length v%0d", i), ce_cnt, tot);
            chk($sformatf("R3 setup length v%0d", i), setup_cnt, v.s + 1);
            chk($sformatf("R3 strobe length v%0d", i), strobe_cnt, v.w + 1);
            chk($sformatf("R3 other strobe v%0d", i), wrong_strobe, 0);
            chk($sformatf("R1 R4 latch lines v%0d", i), latch_err, 0);
            chk($sformatf("R5 bus release v%0d", i), hz_cnt, hz_exp);
            chk($sformatf("R5 bus data v%0d", i), data_err, 0);
            chk($sformatf("R6 rsp count v%0d", i), rsp_seen, v.wr ? 0 : 1);
            if (!v.wr) chk($sformatf("R6 rsp data v%0d", i), rsp_ok, 1);
            chk($sformatf("R1 latch low after v%0d", i), {nf_cle, nf_ale}, 0);
        end

        // R8: wait disabled, busy ignored
        cfg_wait_en = 0;
        nf_rb = 0;
        run_access('{1'b1, 18'h10000, 8'h60, 4'd0, 4'd0, 4'd0, 4'd0}, ce_cnt, setup_cnt,
                   strobe_cnt, wrong_strobe, latch_err, hz_cnt, data_err, rsp_ok, rsp_seen);
        chk("R8 ce length with rb low", ce_cnt, 3);
        repeat (4) @(negedge clk);
        chk("R8 ce_n high while rb low", nf_ce_n, 1);
        chk("R8 req_ready while rb low", req_ready, 1);
        nf_rb = 1;
        repeat (4) @(negedge clk);

        // R7: wait enabled, ce held through busy
        cfg_wait_en = 1;
        cfg_setup = 1; cfg_wait = 1; cfg_hold = 1; cfg_hiz = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 18'h10000; req_wdata = 8'h30;
        @(negedge clk);
        req_valid = 0;
        nf_rb = 0;
        repeat (12) @(negedge clk);
        chk("R7 ce_n held during busy", nf_ce_n, 0);
        chk("R7 req_ready low during busy", req_ready, 0);
        chk("R7 strobes idle during busy", {nf_re_n, nf_we_n}, 3);
        nf_rb = 1;
        repeat (4) @(negedge clk);
        chk("R7 ce_n released after ready", nf_ce_n, 1);
        chk("R7 req_ready after ready", req_ready, 1);
        cfg_wait_en = 0;

        // R9 R10: interrupt sources
        chk("R9 no status with enables off", irq_status, 0);
        cfg_irq_fall_en = 1;
        nf_rb = 0;
        repeat (4) @(negedge clk);
        chk("R9 fall edge status", irq_status, 3'b100);
        chk("R9 irq on fall", irq, 1);
        repeat (6) @(negedge clk);
        chk("R10 fall bit sticky", irq_status, 3'b100);
        irq_clr = 3'b100; @(negedge clk); irq_clr = 3'b000;
        chk("R10 fall bit cleared", irq_status, 3'b000);
        chk("R10 irq low after clear", irq, 0);
        cfg_irq_fall_en = 0;
        cfg_irq_rise_en = 1;
        nf_rb = 1;
        repeat (4) @(negedge clk);
        chk("R9 rise edge status", irq_status, 3'b001);
        irq_clr = 3'b001; @(negedge clk); irq_clr = 3'b000;
        cfg_irq_rise_en = 0;
        chk("R10 rise bit cleared", irq_status, 3'b000);
        cfg_irq_level_en = 1;
        @(negedge clk);
        chk("R9 level status", irq_status, 3'b010);
        irq_clr = 3'b010; @(negedge clk); irq_clr = 3'b000;
        chk("R10 set wins over clear", irq_status, 3'b010);
        cfg_irq_level_en = 0;
        irq_clr = 3'b010; @(negedge clk); irq_clr = 3'b000;
        chk("R10 level cleared when disabled", irq_status, 3'b000);
        nf_rb = 0;
        repeat (4) @(negedge clk);
        nf_rb = 1;
        repeat (4) @(negedge clk);
        chk("R9 toggles ignored when disabled", irq_status, 3'b000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule